// File: doc/BRIEF.md
# Bridge Function-0 Configuration Space

This block holds the 256-byte configuration space of function 0 of a system I/O bridge. A simple access port presents a function number, a byte offset, a write strobe with write data, and returns the addressed byte on a combinational read path. Each write passes through a per-offset filter. Identification bytes cannot be changed. Command and status bytes are forced to fixed patterns. All other offsets store the byte as written.

Two bytes of the space drive feature enables for logic outside the block. Bit 6 of offset 0x40 turns off the DMA register alias. Bit 6 of offset 0x4F turns on the port-92 decode. Each enable is a registered level and comes with a one-cycle pulse in the cycle its level changes. Four routing bytes steer the four PCI interrupt lines to a 4-bit IRQ number, or mark a line as disabled. Reset puts every byte back to a defined value.

Top module: `cfgsp_bridge_cfg`

## Requirements
- R1: An access whose function number is nonzero changes no register and reads back 0xFF.
- R2: Offsets 0x00..0x03 read 0x86, 0x80, 0x84, 0x04. Offset 0x08 reads 0x03. Offsets 0x09..0x0B and 0x0E read 0x00. Writes to any of these offsets are discarded.
- R3: A write to offset 0x04 stores (data AND 0x08) OR 0x07. Writes to 0x05 and 0x06 store 0x00, and writes to 0x07 store 0x02.
- R4: A function-0 write to any other offset stores the byte unchanged, and a read in the next cycle returns it.
- R5: After reset, these offsets hold these values: 0x04=0x07, 0x07=0x02, 0x40=0x20, 0x42=0x04, 0x44=0x20, 0x45=0x10, 0x46=0x0F, 0x48=0x01, 0x49=0x10, 0x4A=0x10, 0x4B=0x0F, 0x4C=0x56, 0x4D=0x40, 0x4E=0x07, 0x4F=0x4F, 0x60..0x63=0x80, 0x80=0x78, 0xA0=0x08, 0xA8=0x0F. Offsets not listed here or in R2 read 0x00.
- R6: `dma_alias_en` is the inverse of bit 6 of offset 0x40. It takes its new value in the cycle after the write edge.
- R7: `p92_en` equals bit 6 of offset 0x4F. It takes its new value in the cycle after the write edge.
- R8: `dma_alias_chg` and `p92_chg` are high for exactly the one cycle in which the matching enable changes level. A write that leaves bit 6 unchanged raises no pulse.
- R9: Offsets 0x60, 0x61, 0x62 and 0x63 route lines A, C, B and D. Output index 0..3 stands for lines A, B, C, D. In `rt_dis` that is bit i, and in `rt_irq` it is bits 4i+3:4i. When bit 7 of a routing byte is set, `rt_dis` is 1 and the IRQ nibble is 0. Otherwise `rt_dis` is 0 and the nibble is bits 3:0 of the routing byte.
- R10: Coming out of reset, `dma_alias_en`=1 and `p92_en`=1, no change pulse is high, and all four lines report disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_func | input | 3 | Function number of the access |
| acc_addr | input | 8 | Byte offset |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| dma_alias_en | output | 1 | DMA register alias active |
| dma_alias_chg | output | 1 | One-cycle pulse on an alias enable change |
| p92_en | output | 1 | Port-92 decode enable |
| p92_chg | output | 1 | One-cycle pulse on a port-92 enable change |
| rt_irq | output | 16 | Routed IRQ nibble per line, A at bits 3:0 up to D at 15:12 |
| rt_dis | output | 4 | Per-line disable flag, A at bit 0 |

## Verification
The write filter is tested with a table of writes to read-only, command/status and plain offsets. Each write uses data with all-ones, all-zeros or mixed bits, so forcing, masking and discarding each produce a different read-back. Writes to the enable bytes alternate between changing bit 6 and rewriting it with the same value. This separates a real level change, which must raise a pulse, from a write that must stay silent. The routing bytes get distinct IRQ numbers on every line, which exposes any swap between lines B and C. Writes with a nonzero function number target both a plain offset and an enable byte, and must leave both unchanged.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
    localparam int FUNC_W    = 3;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_LINES = 4;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int IRQ_W     = 4;

    localparam logic [ADDR_W-1:0] OFF_CMD    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ALIAS  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_P92    = 8'h4F;
    localparam logic [ADDR_W-1:0] OFF_ROUTE  = 8'h60;
    localparam int                CTL_BIT    = 6;
    localparam int                DIS_BIT    = 7;

    typedef logic [DATA_W-1:0] byte_t;

    // Power-on contents of every offset
    function automatic byte_t init_val(input logic [ADDR_W-1:0] a);
        case (a)
            8'h00: init_val = 8'h86;
            8'h01: init_val = 8'h80;
            8'h02: init_val = 8'h84;
            8'h03: init_val = 8'h04;
            8'h04: init_val = 8'h07;
            8'h07: init_val = 8'h02;
            8'h08: init_val = 8'h03;
            8'h40: init_val = 8'h20;
            8'h42: init_val = 8'h04;
            8'h44: init_val = 8'h20;
            8'h45: init_val = 8'h10;
            8'h46: init_val = 8'h0F;
            8'h48: init_val = 8'h01;
            8'h49: init_val = 8'h10;
            8'h4A: init_val = 8'h10;
            8'h4B: init_val = 8'h0F;
            8'h4C: init_val = 8'h56;
            8'h4D: init_val = 8'h40;
            8'h4E: init_val = 8'h07;
            8'h4F: init_val = 8'h4F;
            8'h60, 8'h61, 8'h62, 8'h63: init_val = 8'h80;
            8'h80: init_val = 8'h78;
            8'hA0: init_val = 8'h08;
            8'hA8: init_val = 8'h0F;
            default: init_val = 8'h00;
        endcase
    endfunction

    // Routing-byte index (offset minus OFF_ROUTE) serving interrupt line i (A..D)
    function automatic int line_slot(input int i);
        case (i)
            0: line_slot = 0;
            1: line_slot = 2;
            2: line_slot = 1;
            default: line_slot = 3;
        endcase
    endfunction

    typedef struct packed {
        logic alias_lvl;
        logic p92_lvl;
    } side_st_t;
endpackage

// File: rtl/cfgsp_wfilter.sv
module cfgsp_wfilter
    import cfgsp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output logic              keep,
    output byte_t             wval
);
    always_comb begin
        keep = 1'b1;
        wval = wdata;
        case (addr)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0E:   keep = 1'b0;
            OFF_CMD: wval = (wdata & 8'h08) | 8'h07;
            8'h05,
            8'h06:   wval = 8'h00;
            8'h07:   wval = 8'h02;
            default: wval = wdata;
        endcase
    end
endmodule

// File: rtl/cfgsp_store.sv
module cfgsp_store
    import cfgsp_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               waddr,
    input  byte_t                           wval,
    input  logic [ADDR_W-1:0]               raddr,
    output byte_t                           rdata,
    output byte_t                           alias_reg,
    output byte_t                           p92_reg,
    output logic [NUM_LINES-1:0][DATA_W-1:0] route_reg
);
    byte_t mem_d [DEPTH];
    byte_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= init_val(ADDR_W'(k));
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata     = mem_q[raddr];
    assign alias_reg = mem_q[OFF_ALIAS];
    assign p92_reg   = mem_q[OFF_P92];

    for (genvar s = 0; s < NUM_LINES; s++) begin : g_rt
        assign route_reg[s] = mem_q[OFF_ROUTE + ADDR_W'(s)];
    end
endmodule

// File: rtl/cfgsp_side.sv
module cfgsp_side
    import cfgsp_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  byte_t                            alias_reg,
    input  byte_t                            p92_reg,
    input  logic [NUM_LINES-1:0][DATA_W-1:0] route_reg,
    output logic                             dma_alias_en,
    output logic                             dma_alias_chg,
    output logic                             p92_en,
    output logic                             p92_chg,
    output logic [NUM_LINES*IRQ_W-1:0]       rt_irq,
    output logic [NUM_LINES-1:0]             rt_dis
);
    localparam byte_t ALIAS_RST = init_val(OFF_ALIAS);
    localparam byte_t P92_RST   = init_val(OFF_P92);

    side_st_t st_d, st_q;

    always_comb begin
        st_d.alias_lvl = alias_reg[CTL_BIT];
        st_d.p92_lvl   = p92_reg[CTL_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.alias_lvl <= ALIAS_RST[CTL_BIT];
            st_q.p92_lvl   <= P92_RST[CTL_BIT];
        end else begin
            st_q <= st_d;
        end
    end

    assign dma_alias_en  = ~alias_reg[CTL_BIT];
    assign p92_en        = p92_reg[CTL_BIT];
    assign dma_alias_chg = alias_reg[CTL_BIT] ^ st_q.alias_lvl;
    assign p92_chg       = p92_reg[CTL_BIT] ^ st_q.p92_lvl;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int SLOT = line_slot(i);
        assign rt_dis[i] = route_reg[SLOT][DIS_BIT];
        assign rt_irq[i*IRQ_W +: IRQ_W] =
            route_reg[SLOT][DIS_BIT] ? '0 : route_reg[SLOT][IRQ_W-1:0];
    end
endmodule

// File: rtl/cfgsp_bridge_cfg.sv
module cfgsp_bridge_cfg
    import cfgsp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FUNC_W-1:0]          acc_func,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic                       acc_wr,
    input  logic [DATA_W-1:0]          acc_wdata,
    output logic [DATA_W-1:0]          acc_rdata,
    output logic                       dma_alias_en,
    output logic                       dma_alias_chg,
    output logic                       p92_en,
    output logic                       p92_chg,
    output logic [NUM_LINES*IRQ_W-1:0] rt_irq,
    output logic [NUM_LINES-1:0]       rt_dis
);
    logic                             func0;
    logic                             keep;
    byte_t                            wval;
    byte_t                            st_rdata;
    byte_t                            alias_reg;
    byte_t                            p92_reg;
    logic [NUM_LINES-1:0][DATA_W-1:0] route_reg;

    assign func0 = (acc_func == '0);

    cfgsp_wfilter u_filt (
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .keep  (keep),
        .wval  (wval)
    );

    cfgsp_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (acc_wr && func0 && keep),
        .waddr     (acc_addr),
        .wval      (wval),
        .raddr     (acc_addr),
        .rdata     (st_rdata),
        .alias_reg (alias_reg),
        .p92_reg   (p92_reg),
        .route_reg (route_reg)
    );

    cfgsp_side u_side (
        .clk           (clk),
        .rst_n         (rst_n),
        .alias_reg     (alias_reg),
        .p92_reg       (p92_reg),
        .route_reg     (route_reg),
        .dma_alias_en  (dma_alias_en),
        .dma_alias_chg (dma_alias_chg),
        .p92_en        (p92_en),
        .p92_chg       (p92_chg),
        .rt_irq        (rt_irq),
        .rt_dis        (rt_dis)
    );

    assign acc_rdata = func0 ? st_rdata : 8'hFF;
endmodule

// File: rtl/cfgsp_bridge_cfg_chk.sv
module cfgsp_bridge_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  acc_func,
    input logic [7:0]  acc_addr,
    input logic        acc_wr,
    input logic [7:0]  acc_rdata,
    input logic        dma_alias_en,
    input logic        dma_alias_chg,
    input logic        p92_en,
    input logic        p92_chg,
    input logic [15:0] rt_irq,
    input logic [3:0]  rt_dis
);
    a_r1_other_func_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_func != 3'd0) |-> (acc_rdata == 8'hFF));

    a_r1_other_func_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_func != 3'd0) |=> $stable(dma_alias_en) && $stable(p92_en));

    a_r8_alias_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dma_alias_en) |-> dma_alias_chg);

    a_r8_alias_pulse_only_change: assert property (@(posedge clk) disable iff (!rst_n)
        dma_alias_chg |-> !$stable(dma_alias_en));

    a_r8_p92_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(p92_en) |-> p92_chg);

    a_r8_p92_pulse_only_change: assert property (@(posedge clk) disable iff (!rst_n)
        p92_chg |-> !$stable(p92_en));

    a_r6_alias_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        dma_alias_chg |-> $past(acc_wr && acc_func == 3'd0 && acc_addr == 8'h40));

    a_r7_p92_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        p92_chg |-> $past(acc_wr && acc_func == 3'd0 && acc_addr == 8'h4F));

    for (genvar i = 0; i < 4; i++) begin : g_rt
        a_r9_disabled_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rt_dis[i] |-> (rt_irq[i*4 +: 4] == 4'd0));
    end
endmodule

bind cfgsp_bridge_cfg cfgsp_bridge_cfg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_func      (acc_func),
    .acc_addr      (acc_addr),
    .acc_wr        (acc_wr),
    .acc_rdata     (acc_rdata),
    .dma_alias_en  (dma_alias_en),
    .dma_alias_chg (dma_alias_chg),
    .p92_en        (p92_en),
    .p92_chg       (p92_chg),
    .rt_irq        (rt_irq),
    .rt_dis        (rt_dis)
);

// File: tb/cfgsp_bridge_cfg_tb.sv
module cfgsp_bridge_cfg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  acc_func = '0;
    logic [7:0]  acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        dma_alias_en, dma_alias_chg, p92_en, p92_chg;
    logic [15:0] rt_irq;
    logic [3:0]  rt_dis;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfgsp_bridge_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .acc_func(acc_func), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .dma_alias_en(dma_alias_en), .dma_alias_chg(dma_alias_chg),
        .p92_en(p92_en), .p92_chg(p92_chg), .rt_irq(rt_irq), .rt_dis(rt_dis)
    );

    // {tag code, offset, write data, expected read-back}
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        {8'd4, 8'h10, 8'hA5, 8'hA5},   // R4
        {8'd4, 8'h44, 8'h3C, 8'h3C},   // R4
        {8'd4, 8'hFF, 8'h5A, 8'h5A},   // R4
        {8'd4, 8'h80, 8'h01, 8'h01},   // R4
        {8'd3, 8'h04, 8'hFF, 8'h0F},   // R3
        {8'd3, 8'h04, 8'h00, 8'h07},   // R3
        {8'd3, 8'h04, 8'hF0, 8'h07},   // R3
        {8'd3, 8'h05, 8'hFF, 8'h00},   // R3
        {8'd3, 8'h06, 8'hAA, 8'h00},   // R3
        {8'd3, 8'h07, 8'h00, 8'h02},   // R3
        {8'd2, 8'h00, 8'h12, 8'h86},   // R2
        {8'd2, 8'h01, 8'h00, 8'h80},   // R2
        {8'd2, 8'h02, 8'h00, 8'h84},   // R2
        {8'd2, 8'h03, 8'hFF, 8'h04},   // R2
        {8'd2, 8'h08, 8'hFF, 8'h03},   // R2
        {8'd2, 8'h09, 8'h11, 8'h00},   // R2
        {8'd2, 8'h0B, 8'h77, 8'h00},   // R2
        {8'd2, 8'h0E, 8'h55, 8'h00}    // R2
    };

    function automatic string tag_of(input int c);
        case (c)
            2: tag_of = "R2";
            3: tag_of = "R3";
            default: tag_of = "R4";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_func = f; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_func = '0;
    endtask

    task automatic rd(input logic [2:0] f, input logic [7:0] a, input string req, input logic [7:0] exp);
        acc_func = f; acc_addr = a;
        #1;
        chk(req, $sformatf("read f%0d @%02h", f, a), {24'd0, acc_rdata}, {24'd0, exp});
        acc_func = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state of outputs
        chk("R10", "alias_en", {31'd0, dma_alias_en}, 1);
        chk("R10", "p92_en", {31'd0, p92_en}, 1);
        chk("R10", "pulses", {30'd0, dma_alias_chg, p92_chg}, 0);
        chk("R10", "rt_dis", {28'd0, rt_dis}, 32'hF);
        chk("R10", "rt_irq", {16'd0, rt_irq}, 0);

        // R5 reset contents, recomputed from the requirement list
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            case (a)
                'h00: e = 8'h86; 'h01: e = 8'h80; 'h02: e = 8'h84; 'h03: e = 8'h04;
                'h04: e = 8'h07; 'h07: e = 8'h02; 'h08: e = 8'h03;
                'h40: e = 8'h20; 'h42: e = 8'h04; 'h44: e = 8'h20; 'h45: e = 8'h10;
                'h46: e = 8'h0F; 'h48: e = 8'h01; 'h49: e = 8'h10; 'h4A: e = 8'h10;
                'h4B: e = 8'h0F; 'h4C: e = 8'h56; 'h4D: e = 8'h40; 'h4E: e = 8'h07;
                'h4F: e = 8'h4F; 'h60, 'h61, 'h62, 'h63: e = 8'h80;
                'h80: e = 8'h78; 'hA0: e = 8'h08; 'hA8: e = 8'h0F;
                default: e = 8'h00;
            endcase
            rd(3'd0, 8'(a), "R5", e);
        end

        // Table of filtered writes (R2 R3 R4)
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VEC[v][23:16], VEC[v][15:8]);
            rd(3'd0, VEC[v][23:16], tag_of(int'(VEC[v][31:24])), VEC[v][7:0]);
        end

        // R1 nonzero function: ignored writes, 0xFF reads
        wr(3'd0, 8'h20, 8'h33);
        wr(3'd1, 8'h20, 8'hCC);
        rd(3'd0, 8'h20, "R1", 8'h33);
        rd(3'd1, 8'h20, "R1", 8'hFF);
        rd(3'd7, 8'h00, "R1", 8'hFF);
        wr(3'd2, 8'h40, 8'h60);
        chk("R1", "alias untouched", {31'd0, dma_alias_en}, 1);
        chk("R1", "no pulse", {31'd0, dma_alias_chg}, 0);

        // R6 R8 DMA alias control
        wr(3'd0, 8'h40, 8'h60);
        chk("R6", "alias off", {31'd0, dma_alias_en}, 0);
        chk("R8", "alias pulse", {31'd0, dma_alias_chg}, 1);
        @(negedge clk);
        chk("R8", "alias pulse one cycle", {31'd0, dma_alias_chg}, 0);
        wr(3'd0, 8'h40, 8'h41);
        chk("R8", "same bit no pulse", {31'd0, dma_alias_chg}, 0);
        chk("R6", "alias stays off", {31'd0, dma_alias_en}, 0);
        wr(3'd0, 8'h40, 8'h00);
        chk("R6", "alias on", {31'd0, dma_alias_en}, 1);
        chk("R8", "alias pulse back", {31'd0, dma_alias_chg}, 1);

        // R7 R8 port-92 control
        wr(3'd0, 8'h4F, 8'h0F);
        chk("R7", "p92 off", {31'd0, p92_en}, 0);
        chk("R8", "p92 pulse", {31'd0, p92_chg}, 1);
        @(negedge clk);
        chk("R8", "p92 pulse one cycle", {31'd0, p92_chg}, 0);
        wr(3'd0, 8'h4F, 8'h00);
        chk("R8", "p92 same bit no pulse", {31'd0, p92_chg}, 0);
        wr(3'd0, 8'h4F, 8'h40);
        chk("R7", "p92 on", {31'd0, p92_en}, 1);
        chk("R8", "p92 pulse back", {31'd0, p92_chg}, 1);

        // R9 routing, lines A C B D at offsets 0x60..0x63
        wr(3'd0, 8'h60, 8'h03);   // A -> 3
        wr(3'd0, 8'h61, 8'h05);   // C -> 5
        wr(3'd0, 8'h62, 8'h0A);   // B -> 10
        wr(3'd0, 8'h63, 8'h8E);   // D disabled
        chk("R9", "rt_dis", {28'd0, rt_dis}, 32'h8);
        chk("R9", "rt_irq", {16'd0, rt_irq}, 32'h05A3);
        wr(3'd0, 8'h63, 8'h0F);
        wr(3'd0, 8'h61, 8'hC7);
        chk("R9", "rt_dis swap", {28'd0, rt_dis}, 32'h4);
        chk("R9", "rt_irq swap", {16'd0, rt_irq}, 32'hF0A3);

        // R10 reset again restores outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "rt_dis after reset", {28'd0, rt_dis}, 32'hF);
        chk("R10", "alias after reset", {31'd0, dma_alias_en}, 1);
        rd(3'd0, 8'h10, "R5", 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule